// File: doc/BRIEF.md
# Delay-Line TDC Bin Calibrator

This block turns the raw bin number of a delay-line time-to-digital converter into a time in picoseconds. Delay-line bins are not equally wide, and a few can be several times wider than the average. Their widths also drift with temperature and supply. The block estimates each bin's width from live hit statistics, a code-density histogram. The hits of a free-running source land uniformly across one clock period, so a bin's share of the hits is its share of the period.

Each valid hit does two things. It is looked up in the table currently in force, and the result is returned one cycle later. While the block is collecting, the hit is also counted in its bin. After a fixed number of counted hits the block walks the bins once. It adds up the width estimates and writes the centre time of every bin into a second copy of the table. It then swaps that copy in and clears the histogram. This cycle repeats without end, so the table keeps following the delay line. Until the first swap, a uniform table is used.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears time_valid. Until the first table swap, bin k maps to floor((2k+1)·TCLK_PS / (2·NBINS)), which is 19 for bin 0 and 2480 for bin 63 at the default parameters.
- R2: A hit presented at a clock edge (hit_valid high) produces time_valid high right after that edge. time_ps then holds the table entry for hit_bin, read from the table that was in force before that edge.
- R3: While collecting, every valid hit adds one to the counter of its bin. The counters are CNT_W bits wide, and the total held over all bins never exceeds 2^EVT_LOG2.
- R4: At the edge where the 2^EVT_LOG2-th counted hit arrives, a rebuild starts. The new entry for bin k is floor((2·TCLK_PS·Σ_{j<k} c_j + TCLK_PS·c_k) / 2^(EVT_LOG2+1)), where c_j are the counts. This is the sum of the widths of the earlier bins plus half the width of bin k, and it never exceeds TCLK_PS.
- R5: The rebuild takes the NBINS+1 edges after the triggering hit. Hits at those edges are still looked up, but they are not counted.
- R6: The new table is swapped in at the last of those edges. A hit at that edge still returns the old entry, and hits from the following edge on return the new one.
- R7: The histogram is cleared at the swap. The next table depends only on hits counted after it, so 2^EVT_LOG2 hits all on bin 10 give 0 for bins 0 to 9, 1250 for bin 10 and 2500 for bins 11 to 63.
- R8: With hit_valid low, time_valid is low after the edge and nothing is counted, whatever hit_bin carries.
- R9: Collection restarts by itself after each swap, so calibration repeats without any outside control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | A raw hit is present this cycle |
| hit_bin | input | BIN_W (6) | Raw delay-line bin number of the hit |
| time_valid | output | 1 | time_ps carries a calibrated result |
| time_ps | output | PS_W (12) | Calibrated hit time within the clock period, in picoseconds |

## Verification
The assertions assume three things about the inputs. rst_n is low at the first clock edge. Each hit is a single-cycle valid with a bin number inside the table. Hits come at most one per cycle, so the histogram total can only reach 2^EVT_LOG2 exactly, at the triggering edge. The bench meets these assumptions by holding reset from time zero and driving one hit or idle per cycle on the falling edge, with 6-bit bin numbers that always address a real bin. It keeps its own model of the count window and the rebuild window. Every lookup it makes is counted in that model, including the scans used to read back a table, so the expected tables stay exact across rounds.

// File: rtl/tdccal_pkg.sv
// Package for the TDC bin calibrator: the phase type shared by the sequencer,
// the top and the checker, and the uniform default mapping used at reset.
package tdccal_pkg;

    typedef enum logic [1:0] {
        PH_COUNT = 2'd0,   // collecting hits into the histogram
        PH_BUILD = 2'd1,   // walking bins, writing the shadow table
        PH_SWAP  = 2'd2    // swap tables, clear histogram
    } cal_phase_e;

    // Centre of bin k when all nbins bins share tclk equally.
    function automatic int uniform_center(int k, int nbins, int tclk);
        return ((2 * k + 1) * tclk) / (2 * nbins);
    endfunction

endpackage

// File: rtl/tdccal_hist_bank.sv
// Code-density histogram: one counter per delay-line bin.
// Assumes at most one increment per cycle; clr has priority over an increment.
module tdccal_hist_bank #(
    parameter int NBINS = 64,
    parameter int CNT_W = 15,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              inc_en,
    input  logic [BIN_W-1:0]                  inc_bin,
    input  logic                              clr,
    output logic [NBINS-1:0][CNT_W-1:0]       counts
);

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        // Count hits landing on bin g; zero on reset or clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                counts[g] <= '0;
            end else if (inc_en && inc_bin == BIN_W'(g)) begin
                counts[g] <= counts[g] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdccal_sequencer.sv
// Calibration sequencer: counts accepted hits, and once 2^EVT_LOG2 have been
// taken it walks every bin once, accumulating scaled widths and producing
// the centre time of each bin for the shadow table, then requests the swap.
// Assumes counts are stable during the build (counting is gated off).
module tdccal_sequencer #(
    parameter int NBINS    = 64,
    parameter int CNT_W    = 15,
    parameter int EVT_LOG2 = 14,
    parameter int TCLK_PS  = 2500,
    parameter int PS_W     = 12,
    localparam int BIN_W   = $clog2(NBINS),
    localparam int ACC_W   = EVT_LOG2 + $clog2(TCLK_PS) + 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hit_valid,
    input  logic [NBINS-1:0][CNT_W-1:0]       counts,
    output tdccal_pkg::cal_phase_e            phase,
    output logic                              count_en,
    output logic [EVT_LOG2-1:0]               ev_cnt,
    output logic                              wr_en,
    output logic [BIN_W-1:0]                  wr_idx,
    output logic [PS_W-1:0]                   wr_ps,
    output logic                              swap
);
    import tdccal_pkg::*;

    logic [ACC_W-1:0] acc;      // TCLK_PS * sum of counts of earlier bins
    logic [ACC_W-1:0] prod;     // TCLK_PS * count of current bin
    logic [ACC_W-1:0] num;      // 2*acc + prod, centre scaled by 2^(EVT_LOG2+1)

    // Hits enter the histogram only while collecting.
    assign count_en = hit_valid && (phase == PH_COUNT);

    // Centre time of the bin under the build pointer.
    always_comb begin
        prod  = ACC_W'(counts[wr_idx]) * ACC_W'(TCLK_PS);
        num   = {acc[ACC_W-2:0], 1'b0} + prod;
        wr_ps = PS_W'(num >> (EVT_LOG2 + 1));
        wr_en = (phase == PH_BUILD);
        swap  = (phase == PH_SWAP);
    end

    // Phase, event counter, build pointer and width accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_COUNT;
            ev_cnt <= '0;
            wr_idx <= '0;
            acc    <= '0;
        end else begin
            case (phase)
                PH_COUNT: begin
                    if (count_en) begin
                        if (ev_cnt == {EVT_LOG2{1'b1}}) begin
                            ev_cnt <= '0;
                            wr_idx <= '0;
                            acc    <= '0;
                            phase  <= PH_BUILD;
                        end else begin
                            ev_cnt <= ev_cnt + 1'b1;
                        end
                    end
                end
                PH_BUILD: begin
                    acc <= acc + prod;
                    if (wr_idx == BIN_W'(NBINS - 1)) begin
                        phase <= PH_SWAP;
                    end else begin
                        wr_idx <= wr_idx + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_COUNT;
                end
            endcase
        end
    end

endmodule

// File: rtl/tdccal_lut_bank.sv
// Double-buffered calibration table with a registered lookup port.
// The active copy serves lookups; the other copy takes build writes and
// becomes active on swap. A lookup at the swap edge reads the old copy.
module tdccal_lut_bank #(
    parameter int NBINS   = 64,
    parameter int PS_W    = 12,
    parameter int TCLK_PS = 2500,
    localparam int BIN_W  = $clog2(NBINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              look_en,
    input  logic [BIN_W-1:0]  look_bin,
    input  logic              wr_en,
    input  logic [BIN_W-1:0]  wr_idx,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic              swap,
    output logic              time_valid,
    output logic [PS_W-1:0]   time_ps,
    output logic              active_sel
);

    logic [PS_W-1:0] tbl [2][NBINS];

    // Table storage: uniform fill on reset, shadow writes, swap of copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_sel <= 1'b0;
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < NBINS; k++) begin
                    tbl[s][k] <= PS_W'(tdccal_pkg::uniform_center(k, NBINS, TCLK_PS));
                end
            end
        end else begin
            if (wr_en) begin
                tbl[~active_sel][wr_idx] <= wr_ps;
            end
            if (swap) begin
                active_sel <= ~active_sel;
            end
        end
    end

    // Registered lookup through the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_valid <= 1'b0;
            time_ps    <= '0;
        end else begin
            time_valid <= look_en;
            if (look_en) begin
                time_ps <= tbl[active_sel][look_bin];
            end
        end
    end

endmodule

// File: rtl/tdc_bin_calibrator.sv
// Top of the TDC bin calibrator. Raw bins are looked up through the active
// table; the histogram, the sequencer and the shadow table rebuild the
// mapping every 2^EVT_LOG2 counted hits. Assumes one hit per cycle at most.
module tdc_bin_calibrator #(
    parameter int NBINS    = 64,
    parameter int CNT_W    = 15,
    parameter int EVT_LOG2 = 14,
    parameter int TCLK_PS  = 2500,
    parameter int PS_W     = 12,
    localparam int BIN_W   = $clog2(NBINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [BIN_W-1:0]  hit_bin,
    output logic              time_valid,
    output logic [PS_W-1:0]   time_ps
);

    tdccal_pkg::cal_phase_e            phase;
    logic                              count_en;
    logic [EVT_LOG2-1:0]               ev_cnt;
    logic [NBINS-1:0][CNT_W-1:0]       counts;
    logic                              wr_en;
    logic [BIN_W-1:0]                  wr_idx;
    logic [PS_W-1:0]                   wr_ps;
    logic                              swap;
    logic                              active_sel;

    tdccal_hist_bank #(.NBINS(NBINS), .CNT_W(CNT_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (count_en),
        .inc_bin (hit_bin),
        .clr     (swap),
        .counts  (counts)
    );

    tdccal_sequencer #(
        .NBINS(NBINS), .CNT_W(CNT_W), .EVT_LOG2(EVT_LOG2),
        .TCLK_PS(TCLK_PS), .PS_W(PS_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .counts    (counts),
        .phase     (phase),
        .count_en  (count_en),
        .ev_cnt    (ev_cnt),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_ps     (wr_ps),
        .swap      (swap)
    );

    tdccal_lut_bank #(.NBINS(NBINS), .PS_W(PS_W), .TCLK_PS(TCLK_PS)) u_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_en    (hit_valid),
        .look_bin   (hit_bin),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_ps      (wr_ps),
        .swap       (swap),
        .time_valid (time_valid),
        .time_ps    (time_ps),
        .active_sel (active_sel)
    );

endmodule

// File: rtl/tdc_cal_checker.sv
// Property checker for the TDC bin calibrator, attached by bind.
// Assumes rst_n is low at the first clock edge.
module tdc_cal_checker #(
    parameter int NBINS    = 64,
    parameter int CNT_W    = 15,
    parameter int EVT_LOG2 = 14,
    parameter int TCLK_PS  = 2500,
    parameter int PS_W     = 12,
    localparam int TOT_W   = CNT_W + $clog2(NBINS),
    localparam int BL_W    = $clog2(NBINS + 1) + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hit_valid,
    input  logic                              time_valid,
    input  logic [PS_W-1:0]                   time_ps,
    input  tdccal_pkg::cal_phase_e            phase,
    input  logic [EVT_LOG2-1:0]               ev_cnt,
    input  logic                              active_sel,
    input  logic [NBINS-1:0][CNT_W-1:0]       counts
);
    import tdccal_pkg::*;

    logic [TOT_W-1:0] total;
    logic [BL_W-1:0]  build_len;

    // Sum of all histogram counters.
    always_comb begin
        total = '0;
        for (int k = 0; k < NBINS; k++) begin
            total = total + TOT_W'(counts[k]);
        end
    end

    // Length of the current build window, held until collection resumes.
    always_ff @(posedge clk) begin
        if (!rst_n || phase == PH_COUNT) build_len <= '0;
        else if (phase == PH_BUILD)      build_len <= build_len + 1'b1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> time_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> !time_valid);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        total <= TOT_W'(2 ** EVT_LOG2));

    p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> time_ps <= PS_W'(TCLK_PS));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_BUILD |=> $stable(total));

    p_evzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_COUNT |-> ev_cnt == '0);

    p_build_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SWAP |-> build_len == BL_W'(NBINS));

    p_swap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_SWAP |=> $stable(active_sel));

    p_swap_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SWAP |=> active_sel != $past(active_sel));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SWAP |=> total == '0);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SWAP |=> phase == PH_COUNT);

endmodule

bind tdc_bin_calibrator tdc_cal_checker #(
    .NBINS(NBINS), .CNT_W(CNT_W), .EVT_LOG2(EVT_LOG2),
    .TCLK_PS(TCLK_PS), .PS_W(PS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .time_valid (time_valid),
    .time_ps    (time_ps),
    .phase      (phase),
    .ev_cnt     (ev_cnt),
    .active_sel (active_sel),
    .counts     (counts)
);

// File: tb/sim_tdc_bin_calibrator.sv
// Directed bench for the TDC bin calibrator with a cycle model of the
// count and rebuild windows computed from the requirements.
module sim_tdc_bin_calibrator;

    localparam int NB   = 64;
    localparam int T    = 2500;
    localparam int L    = 14;
    localparam int NEV  = 1 << L;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_valid = 1'b0;
    logic [5:0] hit_bin = '0;
    logic       time_valid;
    logic [11:0] time_ps;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    // model state
    int mcnt [NB];
    int mact [NB];
    int mpend [NB];
    int mev = 0;
    int busy = 0;
    int rounds = 0;

    always #2 clk = ~clk;

    tdc_bin_calibrator u0 (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_bin(hit_bin),
        .time_valid(time_valid), .time_ps(time_ps)
    );

    task automatic check_eq(input int act, input int exp, input string req);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R4: centre of bin k = (2*T*sum earlier + T*c_k) >> (L+1)
    task automatic model_build();
        longint acc = 0;
        for (int k = 0; k < NB; k++) begin
            mpend[k] = int'((2 * acc + longint'(mcnt[k]) * T) >> (L + 1));
            acc += longint'(mcnt[k]) * T;
            mcnt[k] = 0;
        end
    endtask

    // One cycle: drive at negedge, model the edge, sample just after it.
    task automatic step(input bit v, input int b, input string req);
        int exp;
        @(negedge clk);
        hit_valid = v;
        hit_bin   = 6'(b);
        exp       = mact[b];
        @(posedge clk);
        if (busy > 0) begin
            busy--;                       // R5: hits not counted in rebuild
            if (busy == 0) begin
                mact = mpend;             // R6: swap at last rebuild edge
                rounds++;
            end
        end else if (v) begin
            mcnt[b]++;
            mev++;
            if (mev == NEV) begin
                model_build();            // R7: histogram cleared
                mev  = 0;
                busy = NB + 1;
            end
        end
        #1;
        check_eq(int'(time_valid), int'(v), {req, " valid (R2/R8)"});
        if (v) check_eq(int'(time_ps), exp, {req, " time"});
    endtask

    task automatic t_reset();
        for (int k = 0; k < NB; k++) begin
            mcnt[k] = 0;
            mact[k] = ((2 * k + 1) * T) / (2 * NB);
        end
        rst_n = 1'b0;
        hit_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        hit_valid = 1'b0;
        #1;
        check_eq(int'(time_valid), 0, "R1 reset valid");
        step(1, 0, "R1");
        check_eq(int'(time_ps), 19, "R1 bin0 default");
        step(1, 63, "R1");
        check_eq(int'(time_ps), 2480, "R1 bin63 default");
        step(1, 31, "R1");
    endtask

    // Uneven distribution with a wide bin 5 and idle gaps; runs through rebuild.
    task automatic t_round_uneven();
        int r0 = rounds;
        int i = 0;
        while (rounds == r0) begin
            step(i % 5 != 4, (i % 8 == 0) ? 5 : ((i * 7 + 3) % NB), "R4/R5/R6");
            i++;
        end
        for (int j = 0; j < 20; j++) step(1, (j * 11) % NB, "R6 after swap");
    endtask

    task automatic t_scan(input string req);
        for (int k = 0; k < NB; k++) step(1, k, req);
    endtask

    task automatic t_round_fill();
        int r0 = rounds;
        int i = 0;
        while (rounds == r0) begin
            step(1, (i % 3 == 0) ? 63 : (i % 3), "R9");
            i++;
        end
        for (int j = 0; j < 70; j++) step(0, j % NB, "R8 idle");
        check_eq(mev, 0, "R9 window restart");
    endtask

    // All hits on bin 10 from a fresh window.
    task automatic t_round_single();
        for (int i = 0; i < NEV; i++) step(1, 10, "R7");
        for (int j = 0; j < 70; j++) step(0, 40, "R8 idle");
        for (int k = 0; k < NB; k++) begin
            step(1, k, "R7 scan");
            check_eq(int'(time_ps), (k < 10) ? 0 : ((k == 10) ? 1250 : T), "R7 single-bin table");
        end
    endtask

    initial begin
        t_reset();
        t_round_uneven();
        t_scan("R4 scan");
        t_round_fill();
        t_scan("R9 scan");
        t_round_fill();
        t_round_single();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule